// File: doc/BRIEF.md
# Page Write Buffer Engine

This block collects the data bytes of one serial memory write command into a page-sized staging buffer and then programs them into the storage array. A command starts with a strobe that carries the target address. The upper address bits choose the page and stay fixed. The lower bits give the first offset inside the page. Each data byte lands at the current offset, and the offset then steps forward modulo the page size, so a long burst wraps around and overwrites bytes it stored earlier.

The command commits only when the chip-select release lands exactly on a byte boundary after at least one data byte. A release in the middle of a byte, or before any data, drops the command. Once committed, the engine holds busy for a fixed, parameterised number of clock cycles, which stands in for the self-timed programming time. During that window it drains every loaded, unprotected buffer location to the memory write port in ascending offset order. When the window closes it emits a one-cycle done pulse. That pulse is also the request to clear the write-enable latch. The serial shifter in front of this block is outside its scope.

Top module: `page_write_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_we_o` are all low.
- R2: A start strobe taken while idle with `wr_en_ok_i` high fixes the page as the address bits above the low `PAGE_W` bits. The first byte goes to the low-bit offset. After each byte the offset increments modulo 2^`PAGE_W`, and the page bits do not change.
- R3: When more than 2^`PAGE_W` bytes arrive, a later byte at an offset replaces the earlier one, and only the last value for each offset is programmed.
- R4: A `cs_rise_i` with `cs_aligned_i` low, or one that comes before any data byte, cancels the command. Busy is not raised, nothing is written and no done pulse follows.
- R5: A start strobe with `wr_en_ok_i` low is dropped, and the bytes and chip-select release that follow cause no write and no busy.
- R6: A committing `cs_rise_i` sampled at clock edge k makes `busy_o` high from edge k+1 for exactly `PROG_CYCLES` cycles.
- R7: During busy, every loaded offset that is not protected is written exactly once, at address {page, offset}, in ascending offset order. Offsets that were never loaded are not written.
- R8: `prot_lvl_i` is sampled at the start strobe. Its encoding is 0 for no protection, 1 for addresses whose top two bits are 11, 2 for addresses whose top bit is 1, and 3 for all addresses. Protected bytes are never written.
- R9: `done_o` is a single-cycle pulse in the first cycle after `busy_o` falls. It marks the write-enable clear, and only committed commands produce it.
- R10: While busy, start strobes, data bytes and chip-select releases are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_start_i | input | 1 | Write command decoded; address valid |
| wr_addr_i | input | ADDR_W | Start address of the write |
| wr_en_ok_i | input | 1 | Write-enable latch state |
| prot_lvl_i | input | 2 | Block protection level |
| byte_vld_i | input | 1 | One data byte is complete |
| byte_i | input | DATA_W | Data byte |
| cs_rise_i | input | 1 | Chip select released |
| cs_aligned_i | input | 1 | The release lies on a byte boundary |
| busy_o | output | 1 | Programming cycle running |
| done_o | output | 1 | Cycle finished; clear write enable |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | DATA_W | Memory write data |

## Verification
The hardest case to reach is a long burst that wraps and overwrites part of the page while block protection cuts across the same page. Only the last value at each offset may reach memory, and a protected offset must stay silent even though it was loaded. The stimulus sweeps every protection level against every page with short bursts, then sends a 70-byte burst that starts two bytes before the page end. The bench keeps its own offset tracker and expected page image, and it compares these against a per-address count of write strobes recorded at the memory port.

// File: rtl/pwe_pkg.sv
// Shared types for the page write engine.
package pwe_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } pwe_state_e;
endpackage

// File: rtl/pwe_prot_chk.sv
// Block protection decoder.
// Given a level and a full address, flags whether that address is read-only.
// Assumes ADDR_W >= 2. Level 1 guards the top quarter, level 2 the top half
// and level 3 the whole array.
module pwe_prot_chk #(
    parameter int ADDR_W = 9
) (
    input  logic [1:0]        lvl_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o
);
    // decode the level against the two top address bits
    always_comb begin
        unique case (lvl_i)
            2'd0:    prot_o = 1'b0;
            2'd1:    prot_o = (addr_i[ADDR_W-1 -: 2] == 2'b11);
            2'd2:    prot_o = addr_i[ADDR_W-1];
            default: prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/pwe_page_buf.sv
// Page staging buffer with per-location loaded mask.
// clr_i sets the write pointer to ofs_i and empties the mask. Each wr_i
// stores a byte at the pointer and advances it modulo the page size.
// Assumes clr_i and wr_i are never both high.
module pwe_page_buf #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [PAGE_W-1:0] ofs_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic [PAGE_W-1:0] rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o,
    output logic              any_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [DATA_W-1:0]     data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;
    logic [PAGE_W-1:0]     ptr_q;

    // pointer and mask: reload on clear, step on every stored byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            mask_q <= '0;
        end else if (clr_i) begin
            ptr_q  <= ofs_i;
            mask_q <= '0;
        end else if (wr_i) begin
            ptr_q         <= ptr_q + 1'b1;
            mask_q[ptr_q] <= 1'b1;
        end
    end

    // byte storage, one register per page location
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[g] <= '0;
            else if (wr_i && ptr_q == PAGE_W'(g))
                data_q[g] <= din_i;
        end
    end

    assign rd_data_o = data_q[rd_idx_i];
    assign rd_vld_o  = mask_q[rd_idx_i];
    assign any_o     = |mask_q;

    // R2: the offset only ever steps by one, wrapping inside the page
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/pwe_prog_seq.sv
// Self-timed programming sequencer.
// A go_i pulse starts a busy window of exactly PROG_CYCLES cycles. The first
// PAGE_BYTES cycles of the window present each buffer index for draining.
// A one-cycle done pulse follows the window. Assumes PROG_CYCLES >= 2^PAGE_W.
module pwe_prog_seq #(
    parameter int PAGE_W      = 6,
    parameter int PROG_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              drain_o,
    output logic [PAGE_W-1:0] idx_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int SPAN       = (PROG_CYCLES > PAGE_BYTES) ? PROG_CYCLES : PAGE_BYTES;
    localparam int CNT_W      = $clog2(SPAN) + 1;
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] DRAINS = CNT_W'(PAGE_BYTES);

    logic [CNT_W-1:0] cnt_q;

    // window counter, busy flag and the trailing done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!busy_o) begin
                if (go_i) begin
                    busy_o <= 1'b1;
                    cnt_q  <= '0;
                end
            end else if (cnt_q == LAST) begin
                busy_o <= 1'b0;
                done_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign idx_o   = cnt_q[PAGE_W-1:0];
    assign drain_o = busy_o && (cnt_q < DRAINS);

    // R9: the done pulse sits right after the busy window
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    // R6: busy holds until the counter reaches its last value
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q != LAST) |=> busy_o);
endmodule

// File: rtl/page_write_engine.sv
// Page write buffer engine.
// Collects the data bytes of one write command into a page buffer. On an
// aligned chip-select release it runs a self-timed cycle that drains loaded,
// unprotected bytes to the memory write port. The serial shifter decodes the
// command and strobes; at most one strobe per cycle is assumed.
module page_write_engine #(
    parameter int ADDR_W      = 9,
    parameter int PAGE_W      = 6,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              wr_en_ok_i,
    input  logic [1:0]        prot_lvl_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              cs_rise_i,
    input  logic              cs_aligned_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);
    import pwe_pkg::*;

    localparam int BASE_W = ADDR_W - PAGE_W;

    pwe_state_e        state_q;
    logic [BASE_W-1:0] base_q;
    logic [1:0]        lvl_q;
    logic              accept, clr, wr, go;
    logic              drain, rd_vld, any_loaded, addr_prot;
    logic [PAGE_W-1:0] idx;
    logic [DATA_W-1:0] rd_data;

    assign accept = (state_q == ST_IDLE) && !busy_o && wr_start_i && wr_en_ok_i;
    assign clr    = accept;
    assign wr     = (state_q == ST_FILL) && byte_vld_i && !cs_rise_i;
    assign go     = (state_q == ST_FILL) && cs_rise_i && cs_aligned_i && any_loaded;

    // command framing: idle until an enabled start, fill until chip select rises
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            lvl_q   <= '0;
        end else if (accept) begin
            state_q <= ST_FILL;
            base_q  <= wr_addr_i[ADDR_W-1:PAGE_W];
            lvl_q   <= prot_lvl_i;
        end else if (state_q == ST_FILL && cs_rise_i) begin
            state_q <= ST_IDLE;
        end
    end

    pwe_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .ofs_i     (wr_addr_i[PAGE_W-1:0]),
        .wr_i      (wr),
        .din_i     (byte_i),
        .rd_idx_i  (idx),
        .rd_data_o (rd_data),
        .rd_vld_o  (rd_vld),
        .any_o     (any_loaded)
    );

    pwe_prog_seq #(.PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .drain_o (drain),
        .idx_o   (idx)
    );

    pwe_prot_chk #(.ADDR_W(ADDR_W)) u_prot (
        .lvl_i  (lvl_q),
        .addr_i (mem_addr_o),
        .prot_o (addr_prot)
    );

    assign mem_addr_o  = {base_q, idx};
    assign mem_wdata_o = rd_data;
    assign mem_we_o    = drain && rd_vld && !addr_prot;

    // R7: memory is only touched inside the busy window
    a_r7_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);
    // R4: a misaligned release never starts a cycle
    a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && cs_rise_i && !cs_aligned_i) |=> !busy_o);
    // R10: the framing logic stays idle during a cycle
    a_r10_idle_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (state_q == ST_IDLE));
endmodule

// File: tb/tb_page_write_engine.sv
module tb_page_write_engine;
    localparam int ADDR_W = 9;
    localparam int PAGE_W = 6;
    localparam int DATA_W = 8;
    localparam int PROG   = 80;
    localparam int NADDR  = 1 << ADDR_W;
    localparam int NPAGE  = 1 << PAGE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_start_i = 1'b0, wr_en_ok_i = 1'b0, byte_vld_i = 1'b0;
    logic cs_rise_i = 1'b0, cs_aligned_i = 1'b0;
    logic [ADDR_W-1:0] wr_addr_i = '0;
    logic [1:0] prot_lvl_i = '0;
    logic [DATA_W-1:0] byte_i = '0;
    logic busy_o, done_o, mem_we_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [DATA_W-1:0] mem_wdata_o;

    always #2.5 clk = ~clk;

    page_write_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                        .PROG_CYCLES(PROG)) dut (.*);

    int checks = 0, failures = 0;
    int wcnt [NADDR];
    logic [7:0] wval [NADDR];
    int total_w, busy_cyc, done_cnt, order_err, done_pos_err, prev_addr;
    logic prev_busy;
    logic exp_set [NPAGE];
    logic [7:0] exp_val [NPAGE];
    int ofs_trk;

    // recorder at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (mem_we_o) begin
            if (prev_addr >= int'(mem_addr_o)) order_err++;
            prev_addr = int'(mem_addr_o);
            wcnt[mem_addr_o]++;
            wval[mem_addr_o] = mem_wdata_o;
            total_w++;
        end
        if (busy_o) busy_cyc++;
        if (done_o) begin
            done_cnt++;
            if (!(prev_busy && !busy_o)) done_pos_err++;
        end
        prev_busy = busy_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int a = 0; a < NADDR; a++) begin wcnt[a] = 0; wval[a] = '0; end
        for (int o = 0; o < NPAGE; o++) begin exp_set[o] = 1'b0; exp_val[o] = '0; end
        total_w = 0; busy_cyc = 0; done_cnt = 0; order_err = 0; done_pos_err = 0;
        prev_addr = -1;
    endtask

    task automatic start(input int addr, input bit en, input int lvl);
        @(negedge clk);
        wr_start_i = 1'b1; wr_addr_i = ADDR_W'(addr); wr_en_ok_i = en;
        prot_lvl_i = 2'(lvl);
        ofs_trk = addr % NPAGE;
        @(negedge clk);
        wr_start_i = 1'b0; prot_lvl_i = 2'd0;
    endtask

    task automatic send(input logic [7:0] b, input bit track);
        @(negedge clk);
        byte_vld_i = 1'b1; byte_i = b;
        if (track) begin
            exp_set[ofs_trk] = 1'b1; exp_val[ofs_trk] = b;
            ofs_trk = (ofs_trk + 1) % NPAGE;
        end
        @(negedge clk);
        byte_vld_i = 1'b0;
    endtask

    // releases chip select; the next falling edge follows the sampling edge
    task automatic release_cs(input bit aligned, input bit exp_busy, input string req);
        @(negedge clk);
        cs_rise_i = 1'b1; cs_aligned_i = aligned;
        @(negedge clk);
        cs_rise_i = 1'b0; cs_aligned_i = 1'b0;
        chk(busy_o == exp_busy, req, int'(busy_o), int'(exp_busy));
    endtask

    function automatic logic [7:0] pat(input int p, input int o, input int i);
        return 8'((p * 37 + o * 5 + i * 11 + 1) & 255);
    endfunction

    function automatic bit is_prot(input int lvl, input int a);
        logic [ADDR_W-1:0] x;
        x = ADDR_W'(a);
        return (lvl == 3) || (lvl == 2 && x[ADDR_W-1]) ||
               (lvl == 1 && x[ADDR_W-1 -: 2] == 2'b11);
    endfunction

    // compares the recorded writes against the expected page image
    task automatic check_page(input int page, input int lvl, input string req);
        int nexp = 0;
        int bad = 0;
        for (int o = 0; o < NPAGE; o++) begin
            int a = page * NPAGE + o;
            bit want = exp_set[o] && !is_prot(lvl, a);
            if (want) begin
                nexp++;
                if (wcnt[a] != 1 || wval[a] != exp_val[o]) begin
                    bad++;
                    $display("FAIL %s addr=%0d actual=%0d/%0d expected=1/%0d",
                             req, a, wcnt[a], wval[a], exp_val[o]);
                end
            end else if (wcnt[a] != 0) begin
                bad++;
                $display("FAIL %s addr=%0d actual=%0d writes expected=0", req, a, wcnt[a]);
            end
        end
        checks++;
        if (bad != 0) failures++;
        chk(total_w == nexp, {req, " R7 write count"}, total_w, nexp);
        chk(order_err == 0, "R7 ascending order", order_err, 0);
    endtask

    task automatic finish_cycle();
        repeat (PROG + 6) @(negedge clk);
        chk(busy_cyc == PROG, "R6 busy length", busy_cyc, PROG);
        chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
        chk(done_pos_err == 0, "R9 done position", done_pos_err, 0);
    endtask

    task automatic expect_nothing(input string req);
        repeat (PROG + 6) @(negedge clk);
        chk(busy_cyc == 0, req, busy_cyc, 0);
        chk(total_w == 0, req, total_w, 0);
        chk(done_cnt == 0, req, done_cnt, 0);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        // R1: state during and right after reset
        chk(busy_o == 0 && done_o == 0 && mem_we_o == 0, "R1 reset outputs",
            int'({busy_o, done_o, mem_we_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0 && mem_we_o == 0, "R1 after reset", int'({busy_o, mem_we_o}), 0);

        // R2 R8: sweep every protection level against every page
        for (int lvl = 0; lvl < 4; lvl++) begin
            for (int p = 0; p < NADDR / NPAGE; p++) begin
                clear_model();
                start(p * NPAGE + 10, 1'b1, lvl);
                for (int i = 0; i < 3; i++) send(pat(p, 10, i + lvl), 1'b1);
                release_cs(1'b1, 1'b1, "R6 busy after aligned release");
                finish_cycle();
                check_page(p, lvl, "R8 protection sweep");
            end
        end

        // R3: 70 bytes starting two before the page end wrap and overwrite
        clear_model();
        start(2 * NPAGE + 62, 1'b1, 0);
        for (int i = 0; i < 70; i++) send(pat(2, 62, i), 1'b1);
        release_cs(1'b1, 1'b1, "R3 busy after wrap burst");
        finish_cycle();
        check_page(2, 0, "R3 wrap overwrite");

        // R2: full page from offset 0, page bits held
        clear_model();
        start(5 * NPAGE, 1'b1, 1);
        for (int i = 0; i < NPAGE; i++) send(pat(5, 0, i), 1'b1);
        release_cs(1'b1, 1'b1, "R2 busy after full page");
        finish_cycle();
        check_page(5, 1, "R2 full page");

        // R5: write enable low drops the command
        clear_model();
        start(NPAGE + 4, 1'b0, 0);
        send(8'h5A, 1'b0);
        release_cs(1'b1, 1'b0, "R5 no busy without enable");
        expect_nothing("R5 dropped command");

        // R4: release in the middle of a byte
        clear_model();
        start(NPAGE + 4, 1'b1, 0);
        send(8'hA5, 1'b0);
        send(8'h3C, 1'b0);
        release_cs(1'b0, 1'b0, "R4 misaligned release");
        expect_nothing("R4 misaligned cancel");

        // R4: release before any data byte
        clear_model();
        start(NPAGE + 4, 1'b1, 0);
        release_cs(1'b1, 1'b0, "R4 empty release");
        expect_nothing("R4 empty cancel");

        // R10: traffic during a running cycle is ignored
        clear_model();
        start(3 * NPAGE + 7, 1'b1, 0);
        send(pat(3, 7, 0), 1'b1);
        release_cs(1'b1, 1'b1, "R10 busy starts");
        start(4 * NPAGE + 1, 1'b1, 0);
        send(8'hEE, 1'b0);
        release_cs(1'b1, 1'b1, "R10 still busy");
        repeat (PROG + 6) @(negedge clk);
        chk(busy_cyc == PROG, "R10 busy length unchanged", busy_cyc, PROG);
        chk(done_cnt == 1, "R10 single done", done_cnt, 1);
        check_page(3, 0, "R10 ignored traffic");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule